// File: doc/BRIEF.md
# ECP Link Direction Turnaround Sequencer

This block moves an ECP parallel link between its two transfer directions. A request to turn the link toward the host hands the data bus to the peripheral. It does this in two steps: it lowers the host acknowledge line, and after a programmable setup delay it lowers the reverse-request line. It then waits for the peripheral's acknowledge line to go low. A request to turn the link back releases the reverse-request line and waits for the acknowledge line to go high again. Once that happens, the host acknowledge line returns high.

Each acknowledge wait is bounded by a cycle-count limit that is derived from the clock frequency (about 35 ms by default). When the limit is reached, the synchronized acknowledge is sampled one more time before a device error is reported. While a turnaround is in progress, a flush output tells the port's local transfer buffer to drop into its plain bidirectional mode. The flush is released on success and on failure alike.

The sequencer keeps a phase register with three values: forward-idle, reverse-idle or unknown. A failed turnaround leaves the phase unknown. From that state, only reset or the terminate input brings the link back to forward-idle.

Top module: `ecp_turn`

## Requirements
- R1: After reset, phase_o is 0 (forward-idle), host_ack_o and rev_req_no are high, and flush_o, done_o, dev_err_o and proto_err_o are low.
- R2: A reverse request accepted in forward-idle drives host_ack_o low in the next cycle. rev_req_no falls exactly SETUP_CYCLES cycles after host_ack_o falls, and never while host_ack_o is high.
- R3: In a forward-to-reverse turnaround, a low acknowledge seen in time sets phase_o to 1 (reverse-idle) and pulses done_o for one cycle. host_ack_o and rev_req_no are left low.
- R4: A forward request accepted in reverse-idle raises rev_req_no in the next cycle while host_ack_o stays low. A high acknowledge seen in time sets phase_o to 0, raises host_ack_o and pulses done_o.
- R5: ack_rev_ni passes through SYNC_STAGES flops. Suppose the peripheral's acknowledge reaches the pin D cycles after the cycle in which rev_req_no changed. The turnaround then succeeds if and only if D <= TIMEOUT_CYCLES - SYNC_STAGES. The last of those chances comes from one extra sample taken after the window expires.
- R6: On failure, dev_err_o pulses alone. It is registered TIMEOUT_CYCLES+1 edges after the rev_req_no change. phase_o becomes 2 (unknown), and both host lines hold their levels.
- R7: flush_o rises with the accepting edge and falls on the edge that registers done_o or dev_err_o.
- R8: proto_err_o pulses for one cycle, and no line or phase changes, in these cases: a request that does not match the phase, both requests in the same cycle, or any request while a turnaround is in progress.
- R9: In the unknown phase, both requests are rejected. terminate_i returns the block to phase 0 with both host lines high and flush_o low.
- R10: terminate_i has priority over everything else. Requests in the same cycle are dropped without proto_err_o, and a turnaround completing in the same cycle gives neither done_o nor dev_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_rev_i | input | 1 | Request turnaround toward the host (peripheral drives data) |
| req_fwd_i | input | 1 | Request turnaround back to host-driven data |
| terminate_i | input | 1 | Abort and return to forward-idle |
| ack_rev_ni | input | 1 | Peripheral acknowledge of reverse request, active low |
| host_ack_o | output | 1 | Host acknowledge line level |
| rev_req_no | output | 1 | Reverse request line, active low |
| flush_o | output | 1 | Buffer flush / plain bidirectional mode request |
| phase_o | output | 2 | 0 forward-idle, 1 reverse-idle, 2 unknown |
| done_o | output | 1 | One-cycle pulse on successful turnaround |
| dev_err_o | output | 1 | One-cycle pulse on acknowledge timeout |
| proto_err_o | output | 1 | One-cycle pulse on a rejected request |

## Verification
terminate_i can land in the same cycle as two other events. The first is a new request. The second is the edge on which a turnaround would complete. The bench provokes the first case by raising terminate_i together with a reverse request. It then expects no proto_err_o, no flush_o and forward-idle lines. For the second case, the bench computes the completion edge arithmetically from SETUP_CYCLES, SYNC_STAGES and the peripheral's response delay, and raises terminate_i exactly for that edge. It then checks that done_o stays low and that the phase reads forward-idle instead of reverse-idle. In both directions, the peripheral's response delay is swept across the whole window to pin down the success and failure boundary and the exact latencies.

// File: rtl/ecp_turn_pkg.sv
package ecp_turn_pkg;
  typedef enum logic [1:0] {
    PH_FWD = 2'd0,
    PH_REV = 2'd1,
    PH_UNK = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_RECHECK
  } state_e;
endpackage

// File: rtl/ecp_turn_sync.sv
module ecp_turn_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= RST_VAL;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ecp_turn_timer.sv
module ecp_turn_timer #(
  parameter int MAX_VAL = 16,
  parameter int CNT_W   = $clog2(MAX_VAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  // load N gives N cycles before zero_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_VAL - 1));

  // R5
  park_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/ecp_turn_fsm.sv
module ecp_turn_fsm
  import ecp_turn_pkg::*;
#(
  parameter int CNT_W          = 8,
  parameter int SETUP_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_rev_i,
  input  logic             req_fwd_i,
  input  logic             terminate_i,
  input  logic             ack_s_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             host_ack_o,
  output logic             rev_req_no,
  output logic             flush_o,
  output phase_e           phase_o,
  output logic             done_o,
  output logic             dev_err_o,
  output logic             proto_err_o
);
  state_e state_q;
  phase_e phase_q;
  logic   dir_fwd_q;  // 1: waiting for ack high, 0: waiting for ack low
  logic   host_ack_q, rev_req_q, flush_q;
  logic   done_q, dev_err_q, proto_err_q;

  logic any_req, go_rev, go_fwd, reject, ack_match, succeed, failing;

  always_comb begin
    any_req   = req_rev_i | req_fwd_i;
    go_rev    = (state_q == ST_IDLE) && req_rev_i && !req_fwd_i && (phase_q == PH_FWD);
    go_fwd    = (state_q == ST_IDLE) && req_fwd_i && !req_rev_i && (phase_q == PH_REV);
    reject    = any_req && !go_rev && !go_fwd;
    ack_match = (ack_s_i == dir_fwd_q);
    succeed   = ((state_q == ST_WAIT) || (state_q == ST_RECHECK)) && ack_match;
    failing   = (state_q == ST_RECHECK) && !ack_match;
    tmr_load_o = !terminate_i &&
                 (go_rev || go_fwd || ((state_q == ST_SETUP) && tmr_zero_i));
    tmr_val_o  = go_rev ? CNT_W'(SETUP_CYCLES) : CNT_W'(TIMEOUT_CYCLES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_FWD;
      dir_fwd_q   <= 1'b0;
      host_ack_q  <= 1'b1;
      rev_req_q   <= 1'b1;
      flush_q     <= 1'b0;
      done_q      <= 1'b0;
      dev_err_q   <= 1'b0;
      proto_err_q <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      dev_err_q   <= 1'b0;
      proto_err_q <= 1'b0;
      if (terminate_i) begin
        state_q    <= ST_IDLE;
        phase_q    <= PH_FWD;
        host_ack_q <= 1'b1;
        rev_req_q  <= 1'b1;
        flush_q    <= 1'b0;
      end else begin
        proto_err_q <= reject;
        if (succeed) begin
          state_q <= ST_IDLE;
          flush_q <= 1'b0;
          done_q  <= 1'b1;
          if (dir_fwd_q) begin
            phase_q    <= PH_FWD;
            host_ack_q <= 1'b1;
          end else begin
            phase_q    <= PH_REV;
          end
        end else if (failing) begin
          state_q   <= ST_IDLE;
          flush_q   <= 1'b0;
          dev_err_q <= 1'b1;
          phase_q   <= PH_UNK;
        end else begin
          unique case (state_q)
            ST_IDLE: begin
              if (go_rev) begin
                state_q    <= ST_SETUP;
                dir_fwd_q  <= 1'b0;
                host_ack_q <= 1'b0;
                flush_q    <= 1'b1;
              end else if (go_fwd) begin
                state_q   <= ST_WAIT;
                dir_fwd_q <= 1'b1;
                rev_req_q <= 1'b1;
                flush_q   <= 1'b1;
              end
            end
            ST_SETUP: begin
              if (tmr_zero_i) begin
                state_q   <= ST_WAIT;
                rev_req_q <= 1'b0;
              end
            end
            ST_WAIT: begin
              if (tmr_zero_i) state_q <= ST_RECHECK;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign host_ack_o  = host_ack_q;
  assign rev_req_no  = rev_req_q;
  assign flush_o     = flush_q;
  assign phase_o     = phase_q;
  assign done_o      = done_q;
  assign dev_err_o   = dev_err_q;
  assign proto_err_o = proto_err_q;

  // R2
  rev_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev_req_q) |-> (!host_ack_q && $past(!host_ack_q)));

  // R4
  release_keeps_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rev_req_q) && !host_ack_q) |-> flush_q);

  // R3
  done_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q != PH_UNK));

  // R6
  err_unknown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_err_q |-> ((phase_q == PH_UNK) && !done_q));

  // R7
  flush_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || dev_err_q) |-> (!flush_q && $past(flush_q)));

  // R8
  reject_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_err_q && !done_q && !dev_err_q) |->
      ((phase_q == $past(phase_q)) && (host_ack_q == $past(host_ack_q))));

  // R9
  unknown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_UNK) && !terminate_i) |=> (phase_q == PH_UNK));
endmodule

// File: rtl/ecp_turn.sv
module ecp_turn #(
  parameter int CLK_HZ         = 50_000_000,
  parameter int TURN_MS        = 35,
  parameter int SETUP_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = (CLK_HZ / 1000) * TURN_MS,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_rev_i,
  input  logic       req_fwd_i,
  input  logic       terminate_i,
  input  logic       ack_rev_ni,
  output logic       host_ack_o,
  output logic       rev_req_no,
  output logic       flush_o,
  output logic [1:0] phase_o,
  output logic       done_o,
  output logic       dev_err_o,
  output logic       proto_err_o
);
  import ecp_turn_pkg::*;

  localparam int MAX_CNT = (SETUP_CYCLES > TIMEOUT_CYCLES) ? SETUP_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             ack_s;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  phase_e           phase;

  ecp_turn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_rev_ni),
    .q_o   (ack_s)
  );

  ecp_turn_timer #(.MAX_VAL(MAX_CNT), .CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  ecp_turn_fsm #(
    .CNT_W         (CNT_W),
    .SETUP_CYCLES  (SETUP_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_rev_i  (req_rev_i),
    .req_fwd_i  (req_fwd_i),
    .terminate_i(terminate_i),
    .ack_s_i    (ack_s),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .host_ack_o (host_ack_o),
    .rev_req_no (rev_req_no),
    .flush_o    (flush_o),
    .phase_o    (phase),
    .done_o     (done_o),
    .dev_err_o  (dev_err_o),
    .proto_err_o(proto_err_o)
  );

  assign phase_o = phase;
endmodule

// File: tb/tb_ecp_turn.sv
module tb_ecp_turn;
  localparam int N = 3;
  localparam int T = 12;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_rev = 1'b0, req_fwd = 1'b0, term = 1'b0, ack_n = 1'b1;
  logic host_ack_o, rev_req_no, flush_o, done_o, dev_err_o, proto_err_o;
  logic [1:0] phase_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecp_turn #(.SETUP_CYCLES(N), .TIMEOUT_CYCLES(T), .SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_rev_i(req_rev), .req_fwd_i(req_fwd),
    .terminate_i(term), .ack_rev_ni(ack_n), .host_ack_o(host_ack_o),
    .rev_req_no(rev_req_no), .flush_o(flush_o), .phase_o(phase_o),
    .done_o(done_o), .dev_err_o(dev_err_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic to_fwd();
    @(negedge clk); term = 1'b1; ack_n = 1'b1;
    @(negedge clk); term = 1'b0;
    chk("R9 terminate phase", phase_o, 0);
    chk("R9 terminate host_ack", host_ack_o, 1);
    chk("R9 terminate rev_req", rev_req_no, 1);
    chk("R9 terminate flush", flush_o, 0);
    repeat (S + 1) @(negedge clk);
  endtask

  task automatic pulse(input bit rv, input bit fw);
    @(negedge clk); req_rev = rv; req_fwd = fw;
    @(negedge clk); req_rev = 1'b0; req_fwd = 1'b0;
  endtask

  task automatic f2r(input int d, output int lat, output bit ok);
    int c;
    int first;
    c = 0; first = -1; lat = -1; ok = 0;
    @(negedge clk); req_rev = 1'b1;
    while (c < N + T + 8) begin
      @(negedge clk); c++;
      if (c == 1) begin
        req_rev = 1'b0;
        chk("R2 host_ack low after accept", host_ack_o, 0);
        chk("R7 flush raised", flush_o, 1);
      end
      if (c == N) chk("R2 rev_req high during setup", rev_req_no, 1);
      if (c == N + 1) chk("R2 rev_req low after setup", rev_req_no, 0);
      if (done_o || dev_err_o) begin lat = c; ok = done_o; break; end
      if (first < 0 && !rev_req_no) first = c;
      if (first >= 0 && c == first + d) ack_n = 1'b0;
    end
  endtask

  task automatic r2f(input int d, output int lat, output bit ok);
    int c;
    int first;
    c = 0; first = -1; lat = -1; ok = 0;
    @(negedge clk); req_fwd = 1'b1;
    while (c < T + 8) begin
      @(negedge clk); c++;
      if (c == 1) begin
        req_fwd = 1'b0;
        chk("R4 rev_req released", rev_req_no, 1);
        chk("R4 host_ack still low", host_ack_o, 0);
      end
      if (done_o || dev_err_o) begin lat = c; ok = done_o; break; end
      if (first < 0 && rev_req_no) first = c;
      if (first >= 0 && c == first + d) ack_n = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lat;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 phase", phase_o, 0);
    chk("R1 host_ack", host_ack_o, 1);
    chk("R1 rev_req", rev_req_no, 1);
    chk("R1 flush", flush_o, 0);
    chk("R1 pulses", {done_o, dev_err_o, proto_err_o}, 0);

    // R8: mismatched and double requests in forward-idle
    pulse(1'b0, 1'b1);
    chk("R8 fwd in fwd proto", proto_err_o, 1);
    chk("R8 fwd in fwd lines", {host_ack_o, rev_req_no, flush_o}, 3'b110);
    chk("R8 fwd in fwd phase", phase_o, 0);
    pulse(1'b1, 1'b1);
    chk("R8 both proto", proto_err_o, 1);
    chk("R8 both lines", {host_ack_o, rev_req_no, flush_o}, 3'b110);
    @(negedge clk);
    chk("R8 proto one cycle", proto_err_o, 0);

    // R3 R5 R6 R9: forward-to-reverse sweep
    for (int d = 0; d <= T; d++) begin
      to_fwd();
      f2r(d, lat, ok);
      chk("R5 f2r outcome", ok, (d <= T - S) ? 1 : 0);
      if (d <= T - S) begin
        chk("R3 done latency", lat, N + d + S + 2);
        chk("R3 phase reverse", phase_o, 1);
        chk("R3 lines low", {host_ack_o, rev_req_no}, 0);
        chk("R7 flush released on success", flush_o, 0);
      end else begin
        chk("R6 error latency", lat, N + T + 2);
        chk("R6 phase unknown", phase_o, 2);
        chk("R6 lines held", {host_ack_o, rev_req_no}, 0);
        chk("R7 flush released on failure", flush_o, 0);
        pulse(1'b0, 1'b1);
        chk("R9 fwd rejected when unknown", proto_err_o, 1);
        chk("R9 still unknown", phase_o, 2);
        pulse(1'b1, 1'b0);
        chk("R9 rev rejected when unknown", proto_err_o, 1);
      end
    end

    // R8: request in reverse-idle that does not match
    to_fwd();
    f2r(0, lat, ok);
    chk("R3 setup for R8", ok, 1);
    pulse(1'b1, 1'b0);
    chk("R8 rev in rev proto", proto_err_o, 1);
    chk("R8 rev in rev phase", phase_o, 1);
    chk("R8 rev in rev lines", {host_ack_o, rev_req_no}, 0);

    // R4 R5 R6: reverse-to-forward sweep
    for (int d = 0; d <= T; d++) begin
      to_fwd();
      f2r(0, lat, ok);
      r2f(d, lat, ok);
      chk("R5 r2f outcome", ok, (d <= T - S) ? 1 : 0);
      if (d <= T - S) begin
        chk("R4 done latency", lat, d + S + 2);
        chk("R4 phase forward", phase_o, 0);
        chk("R4 host_ack high", host_ack_o, 1);
      end else begin
        chk("R6 r2f error latency", lat, T + 2);
        chk("R6 r2f phase unknown", phase_o, 2);
        chk("R6 r2f lines held", {host_ack_o, rev_req_no}, 2'b01);
      end
    end

    // R8: request while busy
    to_fwd();
    @(negedge clk); req_rev = 1'b1;
    @(negedge clk); req_rev = 1'b0; req_fwd = 1'b1;
    @(negedge clk); req_fwd = 1'b0;
    chk("R8 busy request proto", proto_err_o, 1);
    chk("R8 busy flush kept", flush_o, 1);
    chk("R8 busy phase kept", phase_o, 0);

    // R10: terminate with a request
    to_fwd();
    @(negedge clk); term = 1'b1; req_rev = 1'b1;
    @(negedge clk); term = 1'b0; req_rev = 1'b0;
    chk("R10 no proto with terminate", proto_err_o, 0);
    chk("R10 no flush with terminate", flush_o, 0);
    chk("R10 host_ack high", host_ack_o, 1);

    // R10: terminate on the completion edge
    to_fwd();
    @(negedge clk); req_rev = 1'b1;
    for (int c = 1; c <= N + S + 2; c++) begin
      @(negedge clk);
      if (c == 1) req_rev = 1'b0;
      if (c == N + 1) ack_n = 1'b0;
      if (c == N + S + 1) term = 1'b1;
      if (c == N + S + 2) begin
        term = 1'b0;
        chk("R10 no done on collision", done_o, 0);
        chk("R10 no error on collision", dev_err_o, 0);
        chk("R10 phase forward", phase_o, 0);
        chk("R10 lines high", {host_ack_o, rev_req_no}, 2'b11);
      end
    end
    @(negedge clk);
    chk("R10 done stays low", done_o, 0);

    summary();
  end
endmodule